// File: doc/BRIEF.md
# ASID-Tagged Translation Buffer with Single-Level Walk

This block translates virtual addresses into physical addresses for one requester. It holds a small fully associative set of translations. Each translation pairs a virtual page number and an address-space identifier (ASID) with a physical frame number. Every request is compared against all stored translations in parallel, using its page number and the ASID of the running process. A match returns the frame with the page offset appended, with no memory traffic. Translations from several processes can sit in the buffer side by side, because the ASID is part of the match.

When no translation matches, the block reads one page-table entry itself. It issues a single read over a plain request/response memory port, at the page-table base register plus the page number. If the entry is valid, the block installs it and answers the request. If the entry is invalid, the block answers with a fault flag. A page-table entry can mark its translation as pinned. Pinned translations are never chosen for replacement and survive a flush. Unpinned translations are replaced through a free slot first, then through a round-robin pointer that steps over pinned slots. Changing the page table takes one base-register write. A flush drops every unpinned translation, for software that does not rely on ASIDs.

Top module: `asid_tlb`

## Requirements
- R1: A request accepted while its page number and the `cur_asid` value both match a valid stored translation raises `rsp_valid` at the next clock edge. `rsp_paddr` then equals the stored frame followed by the request's low 12 offset bits, `rsp_fault` is 0, and no memory read is issued.
- R2: A stored translation whose page number matches but whose ASID differs from `cur_asid` does not hit, and the request performs a table read.
- R3: On a miss, exactly one memory read is issued, at address `base + page number` (page number zero-extended). `mem_req_valid` and `mem_req_addr` are held until `mem_req_ready`, and the response appears the cycle after `mem_rsp_valid`.
- R4: After a valid entry is fetched, it is installed, so that a repeat of the same page number and ASID hits. Translations of the same page number under different ASIDs are kept at the same time.
- R5: Page-table entry format: bit 0 is valid, bit 1 is pinned, bits [21:2] are the frame. A fetched entry with bit 0 clear gives `rsp_fault`=1 with `rsp_paddr`=0, and installs nothing.
- R6: An install uses the lowest-numbered invalid slot when one exists. Otherwise it uses the first unpinned slot at or after the round-robin pointer, and the pointer then moves to the slot after the victim. A valid pinned slot is never overwritten.
- R7: When every slot holds a pinned translation, a miss still returns the fetched translation, and nothing is installed.
- R8: Holding `flush` high for one cycle while idle invalidates every unpinned translation and keeps pinned ones. No request is accepted in that cycle. A flush raised while a walk is in progress has no effect.
- R9: A base-register load takes one `base_we` cycle. Walks accepted afterwards use the new base, and translations already stored still hit.
- R10: `req_ready` is low from the cycle after a miss is accepted until its response is returned.
- R11: After reset, the buffer holds no translations, the base is 0, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load the page-table base register |
| base_wdata | input | 32 | New page-table base |
| cur_asid | input | 8 | ASID of the running process |
| flush | input | 1 | Invalidate all unpinned translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address (page number in bits 31:12) |
| rsp_valid | output | 1 | Translation result valid (one-cycle pulse) |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Fetched entry was invalid |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 22 | Page-table entry |

## Verification
The bench fills the buffer and then forces round-robin evictions. It interleaves hits so that a victim choice based on recency, or a pointer that does not advance, shows up as an unexpected table read. It loads the same page under two ASIDs: a design that ignores the ASID would return the other process's frame without a read, or would replace one entry with the other. Pinned entries are stressed until every slot is pinned. A design that evicts them, or that installs over them when no slot is free, loses kernel translations and issues reads where hits are expected. A flush raised during a stalled walk checks that flushes are gated: an early flush would force a read on the next reference to a cached page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Walk sequencer states
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_e;

  // Page-table entry flag positions
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_PIN_BIT   = 1;
  localparam int PTE_FLAG_W    = 2;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_pinned,
  input  logic               flush,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] pinned_vec
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] pin_q, pin_d;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];

  // Parallel compare of page number and ASID in every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
  end

  // Valid and pinned flags: next state
  always_comb begin
    valid_d = valid_q;
    pin_d   = pin_q;
    if (flush) begin
      valid_d = valid_q & pin_q;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      pin_d[wr_idx]   = wr_pinned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pin_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pin_q   <= pin_d;
    end
  end

  // Payload storage, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      pfn_q[wr_idx]  <= wr_pfn;
    end
  end

  assign valid_vec  = valid_q;
  assign pinned_vec = pin_q;

  // R4: a page/ASID pair is never held in two slots
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R8: after a flush only pinned slots stay valid
  assert_flush_keeps_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == $past(valid_q & pin_q)));

  // R6: an install never lands on a valid pinned slot
  assert_pinned_not_overwritten_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(valid_q[wr_idx] && pin_q[wr_idx]));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] pinned_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   vic_idx,
  output logic               vic_ok
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx, rr_idx;
  logic             free_hit, rr_hit;

  // Lowest-numbered empty slot
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // First unpinned slot at or after the round-robin pointer
  always_comb begin
    int j;
    rr_hit = 1'b0;
    rr_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      j = int'(rr_q) + k;
      if (j >= ENTRIES) j = j - ENTRIES;
      if (!(valid_vec[j] && pinned_vec[j])) begin
        rr_hit = 1'b1;
        rr_idx = IDX_W'(j);
      end
    end
  end

  assign vic_idx = free_hit ? free_idx : rr_idx;
  assign vic_ok  = free_hit || rr_hit;

  always_comb begin
    rr_d = rr_q;
    if (advance && !free_hit && rr_hit) begin
      rr_d = (rr_idx == IDX_W'(ENTRIES - 1)) ? '0 : rr_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R6: the chosen victim is never a live pinned slot
  assert_victim_unpinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vic_ok |-> !(valid_vec[vic_idx] && pinned_vec[vic_idx]));

  // R7: no victim exists only when every slot is live and pinned
  assert_no_victim_all_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_ok |-> (&(valid_vec & pinned_vec)));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int MEM_AW  = 32,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int PTE_W  = PFN_W + tlb_pkg::PTE_FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_wdata,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  import tlb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  walk_state_e       state_q, state_d;
  logic [MEM_AW-1:0] base_q, base_d;
  logic [VPN_W-1:0]  wk_vpn_q, wk_vpn_d;
  logic [OFF_W-1:0]  wk_off_q, wk_off_d;
  logic [ASID_W-1:0] wk_asid_q, wk_asid_d;
  logic [MEM_AW-1:0] wk_addr_q, wk_addr_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [PA_W-1:0]   rsp_paddr_q, rsp_paddr_d;
  logic              rsp_fault_q, rsp_fault_d;

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic               accept, lk_hit, cam_flush, install;
  logic [PFN_W-1:0]   lk_pfn, pte_pfn;
  logic               pte_ok, pte_pin;
  logic [ENTRIES-1:0] valid_vec, pinned_vec;
  logic [IDX_W-1:0]   vic_idx;
  logic               vic_ok;

  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign req_off   = req_vaddr[OFF_W-1:0];
  assign req_ready = (state_q == WALK_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign cam_flush = flush && (state_q == WALK_IDLE);

  assign pte_ok  = mem_rsp_data[PTE_VALID_BIT];
  assign pte_pin = mem_rsp_data[PTE_PIN_BIT];
  assign pte_pfn = mem_rsp_data[PTE_W-1:PTE_FLAG_W];
  assign install = (state_q == WALK_WAIT) && mem_rsp_valid && pte_ok && vic_ok;

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vpn    (req_vpn),
    .lk_asid   (cur_asid),
    .lk_hit    (lk_hit),
    .lk_pfn    (lk_pfn),
    .wr_en     (install),
    .wr_idx    (vic_idx),
    .wr_vpn    (wk_vpn_q),
    .wr_asid   (wk_asid_q),
    .wr_pfn    (pte_pfn),
    .wr_pinned (pte_pin),
    .flush     (cam_flush),
    .valid_vec (valid_vec),
    .pinned_vec(pinned_vec)
  );

  tlb_victim #(
    .ENTRIES(ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .pinned_vec(pinned_vec),
    .advance   (install),
    .vic_idx   (vic_idx),
    .vic_ok    (vic_ok)
  );

  // Sequencer and response: next state
  always_comb begin
    state_d     = state_q;
    base_d      = base_we ? base_wdata : base_q;
    wk_vpn_d    = wk_vpn_q;
    wk_off_d    = wk_off_q;
    wk_asid_d   = wk_asid_q;
    wk_addr_d   = wk_addr_q;
    rsp_valid_d = 1'b0;
    rsp_paddr_d = rsp_paddr_q;
    rsp_fault_d = 1'b0;
    case (state_q)
      WALK_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = {lk_pfn, req_off};
          end else begin
            wk_vpn_d  = req_vpn;
            wk_off_d  = req_off;
            wk_asid_d = cur_asid;
            wk_addr_d = base_q + MEM_AW'(req_vpn);
            state_d   = WALK_ISSUE;
          end
        end
      end
      WALK_ISSUE: begin
        if (mem_req_ready) state_d = WALK_WAIT;
      end
      WALK_WAIT: begin
        if (mem_rsp_valid) begin
          rsp_valid_d = 1'b1;
          if (pte_ok) begin
            rsp_paddr_d = {pte_pfn, wk_off_q};
          end else begin
            rsp_paddr_d = '0;
            rsp_fault_d = 1'b1;
          end
          state_d = WALK_IDLE;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WALK_IDLE;
      base_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      base_q      <= base_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_fault_q <= rsp_fault_d;
    end
  end

  // Walk context: captured on accept, no reset needed
  always_ff @(posedge clk) begin
    wk_vpn_q  <= wk_vpn_d;
    wk_off_q  <= wk_off_d;
    wk_asid_q <= wk_asid_d;
    wk_addr_q <= wk_addr_d;
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_paddr     = rsp_paddr_q;
  assign rsp_fault     = rsp_fault_q;
  assign mem_req_valid = (state_q == WALK_ISSUE);
  assign mem_req_addr  = wk_addr_q;

  // R1: an accepted hit answers next cycle without a table read
  assert_hit_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit) |=> (rsp_valid && !mem_req_valid));

  // R3: a stalled read holds its address
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: one handshake per walk
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R5: a fault carries a zero address
  assert_fault_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && (rsp_paddr == '0)));

  // R10: no new request while a read is pending
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_we;
  logic [31:0] base_wdata;
  logic [7:0]  cur_asid;
  logic        flush;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [21:0] mem_rsp_data;

  always #4 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .cur_asid(cur_asid), .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Page table model and remembered translations
  logic [21:0] ptes   [logic [31:0]];
  logic [21:0] cached [logic [27:0]];
  logic [31:0] base_m = '0;

  // Scoreboard
  logic [32:0] sb_q   [$];
  string       sb_tag [$];
  logic [32:0] sb_e;
  string       sb_t;

  // Memory responder state
  int          stall_cfg = 0, lat_cfg = 1, stall_left = 0, rsp_cnt = 0, mem_reads = 0;
  logic [31:0] rsp_addr = '0, last_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = ptes.exists(rsp_addr) ? ptes[rsp_addr] : '0;
        end
      end else if (rst_n && mem_req_valid) begin
        if (stall_left > 0) stall_left--;
        else begin
          mem_req_ready = 1'b1;
          rsp_addr   = mem_req_addr;
          last_addr  = mem_req_addr;
          mem_reads++;
          rsp_cnt    = lat_cfg;
          stall_left = stall_cfg;
        end
      end
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1", "unexpected response", {31'd0, rsp_fault, rsp_paddr}, 64'd0);
        end else begin
          sb_e = sb_q.pop_front();
          sb_t = sb_tag.pop_front();
          check({rsp_fault, rsp_paddr} == sb_e, sb_t, "response {fault,paddr}",
                {31'd0, rsp_fault, rsp_paddr}, {31'd0, sb_e});
        end
      end
    end
  end

  task automatic set_mem(input int stall, input int lat);
    stall_cfg  = stall;
    stall_left = stall;
    lat_cfg    = lat;
  endtask

  task automatic put_pte(input logic [19:0] vpn, input logic [19:0] pfn,
                         input bit ok, input bit pin);
    ptes[base_m + 32'(vpn)] = {pfn, pin, ok};
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we    = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    base_m  = b;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush     = 1'b1;
    req_valid = 1'b1;
    #1;
    check(req_ready == 1'b0, "R8", "ready during flush", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    flush     = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "no response to request held with flush",
          {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic translate(input logic [19:0] vpn, input logic [11:0] off,
                           input logic [7:0] a, input bit exp_walk,
                           input bit flush_mid, input string tag);
    logic [31:0] addr;
    logic [21:0] pte;
    logic [32:0] exp;
    int          reads0;
    addr = base_m + 32'(vpn);
    if (exp_walk) begin
      pte = ptes.exists(addr) ? ptes[addr] : '0;
      if (pte[0]) cached[{a, vpn}] = pte;
    end else begin
      pte = cached.exists({a, vpn}) ? cached[{a, vpn}] : '0;
    end
    exp = pte[0] ? {1'b0, pte[21:2], off} : {1'b1, 32'd0};
    sb_q.push_back(exp);
    sb_tag.push_back(tag);
    reads0 = mem_reads;
    @(negedge clk);
    cur_asid  = a;
    req_vaddr = {vpn, off};
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_walk) begin
      check(req_ready == 1'b0, "R10", "ready while walking", {63'd0, req_ready}, 64'd0);
      if (flush_mid) begin
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    end else begin
      check(rsp_valid == 1'b1, "R1", "hit answered next cycle", {63'd0, rsp_valid}, 64'd1);
    end
    while (sb_q.size() != 0) @(negedge clk);
    check((mem_reads - reads0) == int'(exp_walk), tag, "table reads",
          64'(mem_reads - reads0), 64'(exp_walk));
    if (exp_walk)
      check(last_addr == addr, "R3", "walk address", {32'd0, last_addr}, {32'd0, addr});
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0; cur_asid = '0;
    flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R11", "outputs in reset",
          {62'd0, rsp_valid, mem_req_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after reset", {63'd0, req_ready}, 64'd1);

    // Page table at base 0
    for (int v = 16'h10; v <= 16'h21; v++) put_pte(20'(v), 20'h80000 + 20'(v), 1'b1, 1'b0);
    put_pte(20'h31, 20'h31310, 1'b1, 1'b0);
    put_pte(20'h30, 20'h44444, 1'b1, 1'b0);
    for (int v = 16'h40; v <= 16'h4F; v++) put_pte(20'(v), 20'h90000 + 20'(v), 1'b1, 1'b1);
    put_pte(20'h50, 20'h55550, 1'b1, 1'b0);
    put_pte(20'h51, 20'h55551, 1'b1, 1'b0);
    put_pte(20'h60, 20'h66660, 1'b1, 1'b0);
    put_pte(20'h77, 20'hFFFFF, 1'b0, 1'b0);

    // R11: buffer empty after reset, base is 0 (first miss reads address 0x10)
    set_mem(2, 3);
    translate(20'h10, 12'h123, 8'd5, 1'b1, 1'b0, "R11");
    set_mem(0, 1);
    for (int v = 16'h11; v <= 16'h1F; v++) translate(20'(v), 12'h0A0, 8'd5, 1'b1, 1'b0, "R3");
    translate(20'h10, 12'h456, 8'd5, 1'b0, 1'b0, "R4");

    // R6: round-robin replacement once full
    translate(20'h20, 12'h001, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h21, 12'h002, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h12, 12'h003, 8'd5, 1'b0, 1'b0, "R6");
    translate(20'h10, 12'h004, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h12, 12'h005, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h14, 12'h006, 8'd5, 1'b0, 1'b0, "R6");

    // R2 / R4: ASID tagging and coexistence
    translate(20'h14, 12'h777, 8'd6, 1'b1, 1'b0, "R2");
    translate(20'h14, 12'h778, 8'd5, 1'b1, 1'b0, "R2");
    translate(20'h14, 12'h779, 8'd6, 1'b0, 1'b0, "R4");
    translate(20'h14, 12'h77A, 8'd5, 1'b0, 1'b0, "R4");

    // R5: invalid entry faults and installs nothing
    translate(20'h77, 12'h100, 8'd5, 1'b1, 1'b0, "R5");
    translate(20'h77, 12'h100, 8'd5, 1'b1, 1'b0, "R5");

    // R9: base register load
    set_base(32'h0000_1000);
    put_pte(20'h30, 20'h33333, 1'b1, 1'b0);
    set_mem(1, 2);
    translate(20'h30, 12'hABC, 8'd5, 1'b1, 1'b0, "R9");
    set_base(32'h0);
    translate(20'h30, 12'hABD, 8'd5, 1'b0, 1'b0, "R9");

    // R8: flush during a walk is ignored
    set_mem(0, 1);
    translate(20'h31, 12'h010, 8'd5, 1'b1, 1'b1, "R8");
    translate(20'h30, 12'h011, 8'd5, 1'b0, 1'b0, "R8");

    // R8: idle flush drops unpinned entries, table reloaded at current base
    do_flush();
    translate(20'h30, 12'h012, 8'd5, 1'b1, 1'b0, "R8");

    // R6: pinned entries survive replacement
    do_flush();
    for (int v = 16'h40; v <= 16'h4E; v++) translate(20'(v), 12'h0, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h50, 12'h050, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h51, 12'h051, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h50, 12'h052, 8'd5, 1'b1, 1'b0, "R6");
    translate(20'h40, 12'h053, 8'd5, 1'b0, 1'b0, "R6");
    translate(20'h4E, 12'h054, 8'd5, 1'b0, 1'b0, "R6");

    // R8: pinned entries survive flush
    do_flush();
    translate(20'h41, 12'h060, 8'd5, 1'b0, 1'b0, "R8");
    translate(20'h50, 12'h061, 8'd5, 1'b1, 1'b0, "R8");

    // R7: every slot pinned
    do_flush();
    translate(20'h4F, 12'h070, 8'd5, 1'b1, 1'b0, "R7");
    translate(20'h60, 12'h071, 8'd5, 1'b1, 1'b0, "R7");
    translate(20'h60, 12'h072, 8'd5, 1'b1, 1'b0, "R7");
    translate(20'h4F, 12'h073, 8'd5, 1'b0, 1'b0, "R7");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule